// File: doc/BRIEF.md
# Modulo and Bit-Reversed Address Generator

This block keeps one data pointer into a 16-bit, byte-addressed data space of 64 Kbytes (32K 16-bit words). Each clock cycle it presents the current pointer as the effective address and, when asked, post-updates it. Three update modes are available. Linear mode steps the pointer up or down by one word or one byte. Circular mode wraps the pointer between a programmable first and last address, so buffer loops need no software bounds checks. Bit-reversed mode steps through a power-of-two buffer in the order a radix-2 FFT needs.

The same pointer output also drives an access address that can be extended into program space. When the window is enabled, an address in the upper half of the data space is rebuilt from an 8-bit page value and the low 15 address bits, and a hit flag is raised. A parameter sets whether the unit has bit-reversed hardware. The unit for the first operand bus has it. A unit for the second operand bus leaves it out and offers only linear and circular modes.

Top module: `agu_core`

## Requirements
- R1: A synchronous active-high reset clears the pointer to 0x0000, so `ea` reads zero and `win_hit` reads 0 in the cycle after reset.
- R2: When `load_vld` is high at a clock edge, `ea` equals `load_addr` after that edge, even when `upd_vld` is also high.
- R3: With `load_vld` and `upd_vld` both low, the pointer holds its value.
- R4: In linear mode (`mod_en`=0, `brev_en`=0) an update adds a step to the pointer, or subtracts it when `upd_dec`=1. The step is 1 when `upd_byte`=1 and 2 otherwise. The result wraps modulo 2^16.
- R5: In circular mode (`mod_en`=1, `brev_en`=0), an incrementing update whose stepped result is greater than `buf_end` loads `buf_start`. Otherwise it takes the stepped result.
- R6: In circular mode, a decrementing update whose stepped result is less than `buf_start`, or that borrows below zero, loads `buf_end`. Otherwise it takes the stepped result.
- R7: In bit-reversed mode (`brev_en`=1), an update adds `brev_step` to pointer bits [15:1] with the carry moving from bit 15 down toward bit 1. The carry out of bit 1 is discarded and bit 0 is unchanged. `upd_dec` and `upd_byte` are ignored. `brev_step` is half the buffer size in bytes, for a power-of-two buffer of 2 to 1024 words.
- R8: When `brev_en` and `mod_en` are both 1, the bit-reversed update is used.
- R9: With `win_en`=0, `acc_addr` is `ea` zero-extended to 23 bits and `win_hit` is 0.
- R10: With `win_en`=1, `acc_addr` is {`win_page`, `ea`[14:0]} and `win_hit` is 1 when `ea`[15] is 1. When `ea`[15] is 0, `acc_addr` is `ea` zero-extended and `win_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_vld | input | 1 | Write `load_addr` into the pointer |
| load_addr | input | 16 | New pointer value |
| upd_vld | input | 1 | Post-update the pointer this cycle |
| upd_dec | input | 1 | 1 = decrement, 0 = increment |
| upd_byte | input | 1 | 1 = byte step (1), 0 = word step (2) |
| mod_en | input | 1 | Enable circular wraparound |
| brev_en | input | 1 | Enable bit-reversed update (has priority) |
| buf_start | input | 16 | First byte address of the circular buffer |
| buf_end | input | 16 | Last byte address of the circular buffer |
| brev_step | input | 16 | Bit-reversed modifier, half the buffer size in bytes |
| win_en | input | 1 | Enable the program-space window |
| win_page | input | 8 | Program-space page for the window |
| ea | output | 16 | Current pointer (effective data address) |
| acc_addr | output | 23 | Access address after window mapping |
| win_hit | output | 1 | Access falls in the program-space window |

## Verification
The bench checks that circular buffers wrap correctly at both ends, with a step that lands exactly on `buf_end` and a step that goes one word past it. A compare done on the old pointer, or one that uses >= instead of >, would wrap one step early or late. It runs a full bit-reversed lap over an 8-word buffer, including the step out of index 7 back to index 0. A normal forward carry, or a carry allowed into bit 0, would leave the buffer or produce an odd address. It also enables both modes together and sets the direction and size inputs in bit-reversed mode, which catches a priority or decode slip. Finally it probes the window across the 0x7FFE/0x8004 boundary with the window on and off, and gives load priority over an update issued in the same cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned PAGE_W = 8;
    localparam int unsigned EXT_W  = PAGE_W + ADDR_W - 1;

    typedef enum logic [1:0] {
        UPD_LINEAR = 2'd0,
        UPD_MODULO = 2'd1,
        UPD_BITREV = 2'd2
    } upd_mode_e;

    typedef struct packed {
        logic dec;
        logic bsize;
    } step_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
    } ring_t;

    // Reverse-carry addition over bits [W-1:1]; bit 0 kept.
    function automatic logic [ADDR_W-1:0] rev_carry_add(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] m
    );
        logic [ADDR_W-1:0] r;
        logic              c;
        r = a;
        c = 1'b0;
        for (int i = ADDR_W - 1; i >= 1; i--) begin
            r[i] = a[i] ^ m[i] ^ c;
            c    = (a[i] & m[i]) | (c & (a[i] ^ m[i]));
        end
        return r;
    endfunction

endpackage

// File: rtl/agu_mode_sel.sv
module agu_mode_sel
    import agu_pkg::*;
#(
    parameter bit HAS_BREV = 1'b1
) (
    input  logic      mod_en,
    input  logic      brev_en,
    output upd_mode_e mode
);
    generate
        if (HAS_BREV) begin : g_brev
            always_comb begin
                if (brev_en)     mode = UPD_BITREV;
                else if (mod_en) mode = UPD_MODULO;
                else             mode = UPD_LINEAR;
            end
        end else begin : g_nobrev
            logic unused_brev;
            assign unused_brev = brev_en;
            always_comb mode = mod_en ? UPD_MODULO : UPD_LINEAR;
        end
    endgenerate
endmodule

// File: rtl/agu_next.sv
module agu_next
    import agu_pkg::*;
(
    input  logic [ADDR_W-1:0] cur,
    input  step_req_t         req,
    input  upd_mode_e         mode,
    input  ring_t             ring,
    input  logic [ADDR_W-1:0] brev_step,
    output logic [ADDR_W-1:0] nxt
);
    localparam int unsigned SW = ADDR_W + 1;

    logic [SW-1:0]     step_w;
    logic [SW-1:0]     stepped;
    logic [ADDR_W-1:0] lin_val;
    logic [ADDR_W-1:0] mod_val;
    logic [ADDR_W-1:0] rev_val;
    logic              over_end;
    logic              under_start;

    always_comb begin
        step_w = req.bsize ? SW'(1) : SW'(2);
        if (req.dec) stepped = {1'b0, cur} - step_w;
        else         stepped = {1'b0, cur} + step_w;
        lin_val = stepped[ADDR_W-1:0];
    end

    // Compare the post-update value against the ring limits.
    always_comb begin
        over_end    = !req.dec && (stepped > {1'b0, ring.last});
        under_start = req.dec && (stepped[SW-1] || (stepped[ADDR_W-1:0] < ring.first));
        if (over_end)         mod_val = ring.first;
        else if (under_start) mod_val = ring.last;
        else                  mod_val = lin_val;
    end

    assign rev_val = rev_carry_add(cur, brev_step);

    always_comb begin
        unique case (mode)
            UPD_MODULO: nxt = mod_val;
            UPD_BITREV: nxt = rev_val;
            default:    nxt = lin_val;
        endcase
    end
endmodule

// File: rtl/agu_window.sv
module agu_window
    import agu_pkg::*;
(
    input  logic [ADDR_W-1:0] ea,
    input  logic              win_en,
    input  logic [PAGE_W-1:0] win_page,
    output logic [EXT_W-1:0]  acc_addr,
    output logic              win_hit
);
    always_comb begin
        win_hit = win_en && ea[ADDR_W-1];
        if (win_hit) acc_addr = {win_page, ea[ADDR_W-2:0]};
        else         acc_addr = {{(EXT_W-ADDR_W){1'b0}}, ea};
    end

    always_comb begin
        // R10
        window_upper_chk: assert (!win_hit || acc_addr[EXT_W-1 -: PAGE_W] == win_page);
    end
endmodule

// File: rtl/agu_core.sv
module agu_core
    import agu_pkg::*;
#(
    parameter bit HAS_BREV = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_vld,
    input  logic [ADDR_W-1:0]   load_addr,
    input  logic                upd_vld,
    input  logic                upd_dec,
    input  logic                upd_byte,
    input  logic                mod_en,
    input  logic                brev_en,
    input  logic [ADDR_W-1:0]   buf_start,
    input  logic [ADDR_W-1:0]   buf_end,
    input  logic [ADDR_W-1:0]   brev_step,
    input  logic                win_en,
    input  logic [PAGE_W-1:0]   win_page,
    output logic [ADDR_W-1:0]   ea,
    output logic [EXT_W-1:0]    acc_addr,
    output logic                win_hit
);
    upd_mode_e         mode;
    step_req_t         req;
    ring_t             ring;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_nxt;

    assign req  = '{dec: upd_dec, bsize: upd_byte};
    assign ring = '{first: buf_start, last: buf_end};

    agu_mode_sel #(.HAS_BREV(HAS_BREV)) u_mode (
        .mod_en  (mod_en),
        .brev_en (brev_en),
        .mode    (mode)
    );

    agu_next u_next (
        .cur       (ptr_q),
        .req       (req),
        .mode      (mode),
        .ring      (ring),
        .brev_step (brev_step),
        .nxt       (ptr_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)           ptr_q <= '0;
        else if (load_vld) ptr_q <= load_addr;
        else if (upd_vld)  ptr_q <= ptr_nxt;
    end

    assign ea = ptr_q;

    agu_window u_win (
        .ea       (ptr_q),
        .win_en   (win_en),
        .win_page (win_page),
        .acc_addr (acc_addr),
        .win_hit  (win_hit)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (ea == '0));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load_vld |=> (ea == $past(load_addr)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_vld && !upd_vld) |=> $stable(ea));

    // R5
    ring_inside_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_vld && upd_vld && mode == UPD_MODULO && ea >= buf_start && ea <= buf_end)
        |=> (ea >= $past(buf_start) && ea <= $past(buf_end)));

    // R7
    brev_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_vld && upd_vld && mode == UPD_BITREV) |=> (ea[0] == $past(ea[0])));

    // R10
    window_low_chk: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> (acc_addr[ADDR_W-2:0] == ea[ADDR_W-2:0]));
endmodule

// File: tb/tb_agu_core.sv
`timescale 1ns/1ps
module tb_agu_core;
    logic        clk = 1'b0;
    logic        rst;
    logic        load_vld, upd_vld, upd_dec, upd_byte, mod_en, brev_en, win_en;
    logic [15:0] load_addr, buf_start, buf_end, brev_step;
    logic [7:0]  win_page;
    logic [15:0] ea;
    logic [22:0] acc_addr;
    logic        win_hit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    agu_core dut (
        .clk(clk), .rst(rst), .load_vld(load_vld), .load_addr(load_addr),
        .upd_vld(upd_vld), .upd_dec(upd_dec), .upd_byte(upd_byte),
        .mod_en(mod_en), .brev_en(brev_en), .buf_start(buf_start),
        .buf_end(buf_end), .brev_step(brev_step), .win_en(win_en),
        .win_page(win_page), .ea(ea), .acc_addr(acc_addr), .win_hit(win_hit)
    );

    // md: 0 linear, 1 circular, 2 bit-reversed, 3 both enabled
    typedef struct packed {
        logic [1:0]  md;
        logic [15:0] init;
        logic        dec;
        logic        bsz;
        logic [3:0]  n;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 16'h0100, 1'b0, 1'b0, 4'd3, 16'h0106},  // R4 word inc
        '{2'd0, 16'h0100, 1'b1, 1'b1, 4'd5, 16'h00FB},  // R4 byte dec
        '{2'd0, 16'hFFFF, 1'b0, 1'b1, 4'd1, 16'h0000},  // R4 wrap
        '{2'd1, 16'h100C, 1'b0, 1'b0, 4'd1, 16'h100E},  // R5 land on end
        '{2'd1, 16'h100C, 1'b0, 1'b0, 4'd2, 16'h1000},  // R5 pass end
        '{2'd1, 16'h1002, 1'b1, 1'b0, 4'd2, 16'h100E},  // R6 pass start
        '{2'd1, 16'h1000, 1'b0, 1'b0, 4'd8, 16'h1000},  // R5 full lap
        '{2'd1, 16'h100D, 1'b0, 1'b1, 4'd2, 16'h1000},  // R5 byte wrap
        '{2'd2, 16'h2000, 1'b0, 1'b0, 4'd3, 16'h200C},  // R7 idx 6
        '{2'd2, 16'h2000, 1'b0, 1'b0, 4'd4, 16'h2002},  // R7 idx 1
        '{2'd2, 16'h2000, 1'b0, 1'b0, 4'd8, 16'h2000},  // R7 full lap
        '{2'd3, 16'h2000, 1'b0, 1'b0, 4'd1, 16'h2008},  // R8 priority
        '{2'd2, 16'h2000, 1'b1, 1'b1, 4'd5, 16'h200A}   // R7 dir/size ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_ptr(input logic [15:0] a);
        @(negedge clk);
        load_vld  = 1'b1;
        load_addr = a;
        @(negedge clk);
        load_vld  = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_vld = 0; upd_vld = 0; upd_dec = 0; upd_byte = 0;
        mod_en = 0; brev_en = 0; win_en = 0; win_page = 8'h00;
        load_addr = '0; buf_start = 16'h1000; buf_end = 16'h100E; brev_step = 16'h0008;
        repeat (3) @(negedge clk);
        check("R1 reset ea", 32'(ea), 32'h0);
        check("R1 reset hit", 32'(win_hit), 32'h0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            mod_en  = (VEC[v].md == 2'd1) || (VEC[v].md == 2'd3);
            brev_en = VEC[v].md[1];
            load_ptr(VEC[v].init);
            upd_vld  = 1'b1;
            upd_dec  = VEC[v].dec;
            upd_byte = VEC[v].bsz;
            repeat (int'(VEC[v].n)) @(negedge clk);
            upd_vld = 1'b0;
            check($sformatf("vector %0d md=%0d (R4-R8 table)", v, VEC[v].md), 32'(ea), 32'(VEC[v].exp));
        end
        mod_en = 0; brev_en = 0;

        // R3: no request leaves pointer unchanged
        load_ptr(16'h0456);
        repeat (4) @(negedge clk);
        check("R3 hold", 32'(ea), 32'h0456);

        // R2: load wins over simultaneous update
        @(negedge clk);
        load_vld = 1'b1; load_addr = 16'h0A00; upd_vld = 1'b1; upd_dec = 1'b0; upd_byte = 1'b0;
        @(negedge clk);
        load_vld = 1'b0; upd_vld = 1'b0;
        check("R2 load priority", 32'(ea), 32'h0A00);

        // R9: window off passes upper half unchanged
        load_ptr(16'h8004);
        win_page = 8'h5A;
        #0.5;
        check("R9 off addr", 32'(acc_addr), 32'h0000_8004);
        check("R9 off hit", 32'(win_hit), 32'h0);

        // R10: window on, upper half mapped
        win_en = 1'b1;
        #0.5;
        check("R10 on addr", 32'(acc_addr), 32'h002D_0004);
        check("R10 on hit", 32'(win_hit), 32'h1);

        // R10: window on, lower half untouched
        load_ptr(16'h7FFE);
        check("R10 low addr", 32'(acc_addr), 32'h0000_7FFE);
        check("R10 low hit", 32'(win_hit), 32'h0);
        win_en = 1'b0;

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset again", 32'(ea), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule